// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block holds the control and mixer state of an audio codec as a bank of sixteen-bit words. Software reaches it through a request/response bus. A request carries a byte index and an access size. Only word-sized accesses at even indices from 0x00 to 0x7E reach storage. Every other access is dropped on write and answers 0xFFFF on read.

Writes are filtered before they reach storage:
- The identification words are read-only.
- The power-down word keeps its status nibble.
- The sample-rate words take new values only while their variable-rate enable is set.
- Clearing an enable pins the related rates to 48 kHz (0xBB80).

Downstream logic reads the decoded state directly: per-channel mute and level, the left and right record sources, and the three live conversion rates.

The request side uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high unless a read response is waiting and `rsp_ready` is low; in that case the block stalls new requests. Writes produce no response. A read raises `rsp_valid` on the edge after it is taken. `rsp_valid` and `rsp_rdata` then stay unchanged until a clock edge sees `rsp_ready` high.

Top module: `codec_mix_regfile`

## Requirements
- R1: After power-on reset, every word reads 0x0000 except these:
  - 0x06 and 0x1E read 0x8000.
  - 0x0C and 0x0E read 0x8008.
  - 0x12 and 0x16 read 0x8808.
  - 0x26 reads 0x000F.
  - 0x28 reads 0x0809.
  - 0x2A reads 0x0009.
  - 0x2C, 0x2E, 0x30, 0x32 and 0x34 read 0xBB80.
- R2: A word write to any ordinary even index is read back unchanged.
- R3: Word writes to 0x28, 0x7C and 0x7E leave their contents unchanged.
- R4: A write to 0x26 stores bits 15:4 of the data and keeps bits 3:0 at their current value.
- R5: Writes to 0x2C and 0x32 are stored only while bit 0 of word 0x2A is 1; otherwise they are dropped.
- R6: Writes to 0x34 are stored only while bit 3 of word 0x2A is 1; otherwise they are dropped.
- R7: Writing 0x2A stores the data. If bit 0 of the data is 0, words 0x2C and 0x32 become 0xBB80 on the same edge. If bit 3 of the data is 0, word 0x34 becomes 0xBB80 on the same edge.
- R8: These accesses are illegal: a size code other than word (size codes are 0 byte, 1 word, 2 dword, 3 reserved), an odd index, or an index of 0x80 or above. Illegal reads return 0xFFFF and illegal writes change nothing.
- R9: Channels 0 to 3 decode words 0x02, 0x10, 0x18 and 0x0E. For each channel:
  - mute is bit 15;
  - the left level is 31 minus bits 12:8;
  - the right level is 31 minus bits 4:0.
- R10: `rec_right` shows bits 2:0 of word 0x1A and `rec_left` shows bits 10:8.
- R11: `rate_front`, `rate_lr` and `rate_mic` show words 0x2C, 0x32 and 0x34.
- R12: `regs_reset` held high for one clock edge restores every R1 default.
- R13: These rules govern the handshake:
  - a read taken on one edge gives `rsp_valid` high after the next edge;
  - while `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response holds stable;
  - a request offered during that stall is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regs_reset | input | 1 | Synchronous restore of all register defaults |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 reserved |
| req_index | input | ADDR_W | Byte index |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 16 | Read data |
| vol_mute | output | NUM_CH | Per-channel mute |
| vol_left | output | NUM_CH*ATT_W | Per-channel left level, channel 0 in the low bits |
| vol_right | output | NUM_CH*ATT_W | Per-channel right level, channel 0 in the low bits |
| rec_left | output | 3 | Left record source |
| rec_right | output | 3 | Right record source |
| rate_front | output | 16 | Front playback rate |
| rate_lr | output | 16 | Stereo capture rate |
| rate_mic | output | 16 | Microphone capture rate |

## Verification
A write lands on the edge that takes it. The decoded outputs are combinational from storage, so they are checked at the falling edge right after that edge. A read response appears after the edge that takes the read, so the bench samples `rsp_rdata` at the following falling edge. The stall case holds `rsp_ready` low for several cycles and checks the response and `req_ready` at each falling edge. All stimulus changes on falling edges, so every sample falls half a period away from the edge that produced it.

// File: rtl/codec_mix_pkg.sv
package codec_mix_pkg;
  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 64;
  localparam int SLOT_W    = $clog2(NUM_WORDS);
  localparam int STATUS_W  = 4;
  localparam int REC_W     = 3;
  localparam int VRA_BIT   = 0;
  localparam int VRM_BIT   = 3;
  localparam logic [WORD_W-1:0] RATE_48K = 16'hBB80;

  // word slots (byte index >> 1)
  localparam logic [SLOT_W-1:0] SL_MONO_VOL   = 6'h03; // 0x06
  localparam logic [SLOT_W-1:0] SL_PHONE_VOL  = 6'h06; // 0x0C
  localparam logic [SLOT_W-1:0] SL_MIC_VOL    = 6'h07; // 0x0E
  localparam logic [SLOT_W-1:0] SL_CD_VOL     = 6'h09; // 0x12
  localparam logic [SLOT_W-1:0] SL_AUX_VOL    = 6'h0B; // 0x16
  localparam logic [SLOT_W-1:0] SL_REC_SEL    = 6'h0D; // 0x1A
  localparam logic [SLOT_W-1:0] SL_MIC_GAIN   = 6'h0F; // 0x1E
  localparam logic [SLOT_W-1:0] SL_PDOWN      = 6'h13; // 0x26
  localparam logic [SLOT_W-1:0] SL_EXT_ID     = 6'h14; // 0x28
  localparam logic [SLOT_W-1:0] SL_EXT_CTL    = 6'h15; // 0x2A
  localparam logic [SLOT_W-1:0] SL_RATE_FRONT = 6'h16; // 0x2C
  localparam logic [SLOT_W-1:0] SL_RATE_SURR  = 6'h17; // 0x2E
  localparam logic [SLOT_W-1:0] SL_RATE_LFE   = 6'h18; // 0x30
  localparam logic [SLOT_W-1:0] SL_RATE_LR    = 6'h19; // 0x32
  localparam logic [SLOT_W-1:0] SL_RATE_MIC   = 6'h1A; // 0x34
  localparam logic [SLOT_W-1:0] SL_ID_HI      = 6'h3E; // 0x7C
  localparam logic [SLOT_W-1:0] SL_ID_LO      = 6'h3F; // 0x7E

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  function automatic logic [WORD_W-1:0] reset_word(input logic [SLOT_W-1:0] s);
    case (s)
      SL_MONO_VOL, SL_MIC_GAIN:  return 16'h8000;
      SL_PHONE_VOL, SL_MIC_VOL:  return 16'h8008;
      SL_CD_VOL, SL_AUX_VOL:     return 16'h8808;
      SL_PDOWN:                  return 16'h000F;
      SL_EXT_ID:                 return 16'h0809;
      SL_EXT_CTL:                return 16'h0009;
      SL_RATE_FRONT, SL_RATE_SURR, SL_RATE_LFE,
      SL_RATE_LR, SL_RATE_MIC:   return RATE_48K;
      default:                   return '0;
    endcase
  endfunction
endpackage

// File: rtl/codec_mix_addr_dec.sv
module codec_mix_addr_dec
  import codec_mix_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [1:0]        size_i,
  output logic              legal_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int TOP_W = ADDR_W - SLOT_W - 1;

  logic in_range;
  assign in_range = (idx_i[ADDR_W-1 -: TOP_W] == '0);
  assign legal_o  = (size_i == SZ_WORD) && !idx_i[0] && in_range;
  assign slot_o   = idx_i[SLOT_W:1];
endmodule

// File: rtl/codec_mix_wr_policy.sv
module codec_mix_wr_policy
  import codec_mix_pkg::*;
(
  input  logic              wr_req_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] cur_word_i,
  input  logic [WORD_W-1:0] ext_ctl_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_val_o,
  output logic              force_ar_o,
  output logic              force_mic_o
);
  always_comb begin
    wr_en_o     = wr_req_i;
    wr_val_o    = wdata_i;
    force_ar_o  = 1'b0;
    force_mic_o = 1'b0;
    if (wr_req_i) begin
      case (slot_i)
        SL_ID_HI, SL_ID_LO, SL_EXT_ID: wr_en_o = 1'b0;
        SL_PDOWN:
          wr_val_o = {wdata_i[WORD_W-1:STATUS_W], cur_word_i[STATUS_W-1:0]};
        SL_RATE_FRONT, SL_RATE_LR: wr_en_o = ext_ctl_i[VRA_BIT];
        SL_RATE_MIC:               wr_en_o = ext_ctl_i[VRM_BIT];
        SL_EXT_CTL: begin
          force_ar_o  = !wdata_i[VRA_BIT];
          force_mic_o = !wdata_i[VRM_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/codec_mix_store.sv
module codec_mix_store
  import codec_mix_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              soft_rst_i,
  input  logic                              wr_en_i,
  input  logic [SLOT_W-1:0]                 wr_slot_i,
  input  logic [WORD_W-1:0]                 wr_val_i,
  input  logic                              force_ar_i,
  input  logic                              force_mic_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  words_o
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    localparam logic [SLOT_W-1:0] THIS   = SLOT_W'(g);
    localparam logic [WORD_W-1:0] DFLT   = reset_word(THIS);
    localparam bit                IS_AR  = (THIS == SL_RATE_FRONT) || (THIS == SL_RATE_LR);
    localparam bit                IS_MIC = (THIS == SL_RATE_MIC);

    logic [WORD_W-1:0] q;
    logic              pin;

    assign pin = (IS_AR && force_ar_i) || (IS_MIC && force_mic_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= DFLT;
      else if (soft_rst_i)                    q <= DFLT;
      else if (wr_en_i && wr_slot_i == THIS)  q <= wr_val_i;
      else if (pin)                           q <= RATE_48K;
    end

    assign words_o[g] = q;
  end
endmodule

// File: rtl/codec_mix_decode.sv
module codec_mix_decode
  import codec_mix_pkg::*;
#(
  parameter int                  NUM_CH   = 4,
  parameter int                  ATT_W    = 5,
  parameter logic [NUM_CH*8-1:0] CH_INDEX = 32'h0E18_1002
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_i,
  output logic [NUM_CH-1:0]                mute_o,
  output logic [NUM_CH*ATT_W-1:0]          left_o,
  output logic [NUM_CH*ATT_W-1:0]          right_o,
  output logic [REC_W-1:0]                 rec_left_o,
  output logic [REC_W-1:0]                 rec_right_o,
  output logic [WORD_W-1:0]                rate_front_o,
  output logic [WORD_W-1:0]                rate_lr_o,
  output logic [WORD_W-1:0]                rate_mic_o
);
  localparam int                LEFT_LSB = 8;
  localparam int                MUTE_BIT = WORD_W - 1;
  localparam logic [ATT_W-1:0]  FULL     = '1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [SLOT_W-1:0] S = CH_INDEX[c*8+1 +: SLOT_W];
    logic [WORD_W-1:0] w;
    assign w                       = words_i[S];
    assign mute_o[c]               = w[MUTE_BIT];
    assign left_o[c*ATT_W +: ATT_W]  = FULL - w[LEFT_LSB +: ATT_W];
    assign right_o[c*ATT_W +: ATT_W] = FULL - w[0 +: ATT_W];
  end

  assign rec_right_o  = words_i[SL_REC_SEL][0 +: REC_W];
  assign rec_left_o   = words_i[SL_REC_SEL][LEFT_LSB +: REC_W];
  assign rate_front_o = words_i[SL_RATE_FRONT];
  assign rate_lr_o    = words_i[SL_RATE_LR];
  assign rate_mic_o   = words_i[SL_RATE_MIC];
endmodule

// File: rtl/codec_mix_regfile.sv
module codec_mix_regfile
  import codec_mix_pkg::*;
#(
  parameter int                  ADDR_W   = 8,
  parameter int                  NUM_CH   = 4,
  parameter int                  ATT_W    = 5,
  parameter logic [NUM_CH*8-1:0] CH_INDEX = 32'h0E18_1002
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      regs_reset,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [1:0]                req_size,
  input  logic [ADDR_W-1:0]         req_index,
  input  logic [WORD_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [WORD_W-1:0]         rsp_rdata,
  output logic [NUM_CH-1:0]         vol_mute,
  output logic [NUM_CH*ATT_W-1:0]   vol_left,
  output logic [NUM_CH*ATT_W-1:0]   vol_right,
  output logic [REC_W-1:0]          rec_left,
  output logic [REC_W-1:0]          rec_right,
  output logic [WORD_W-1:0]         rate_front,
  output logic [WORD_W-1:0]         rate_lr,
  output logic [WORD_W-1:0]         rate_mic
);
  logic                              legal;
  logic [SLOT_W-1:0]                 slot;
  logic                              take;
  logic                              wr_req;
  logic                              rd_take;
  logic                              wr_en;
  logic [WORD_W-1:0]                 wr_val;
  logic                              force_ar;
  logic                              force_mic;
  logic [NUM_WORDS-1:0][WORD_W-1:0]  words;
  logic [WORD_W-1:0]                 ext_ctl_w;
  logic [WORD_W-1:0]                 pdown_w;
  logic [WORD_W-1:0]                 ext_id_w;
  logic                              rsp_valid_q;
  logic [WORD_W-1:0]                 rsp_rdata_q;

  codec_mix_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .idx_i   (req_index),
    .size_i  (req_size),
    .legal_o (legal),
    .slot_o  (slot)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign take      = req_valid && req_ready;
  assign wr_req    = take && req_write && legal;
  assign rd_take   = take && !req_write;

  assign ext_ctl_w = words[SL_EXT_CTL];
  assign pdown_w   = words[SL_PDOWN];
  assign ext_id_w  = words[SL_EXT_ID];

  codec_mix_wr_policy u_pol (
    .wr_req_i    (wr_req),
    .slot_i      (slot),
    .wdata_i     (req_wdata),
    .cur_word_i  (words[slot]),
    .ext_ctl_i   (ext_ctl_w),
    .wr_en_o     (wr_en),
    .wr_val_o    (wr_val),
    .force_ar_o  (force_ar),
    .force_mic_o (force_mic)
  );

  codec_mix_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst_i  (regs_reset),
    .wr_en_i     (wr_en),
    .wr_slot_i   (slot),
    .wr_val_i    (wr_val),
    .force_ar_i  (force_ar),
    .force_mic_i (force_mic),
    .words_o     (words)
  );

  codec_mix_decode #(.NUM_CH(NUM_CH), .ATT_W(ATT_W), .CH_INDEX(CH_INDEX)) u_out (
    .words_i      (words),
    .mute_o       (vol_mute),
    .left_o       (vol_left),
    .right_o      (vol_right),
    .rec_left_o   (rec_left),
    .rec_right_o  (rec_right),
    .rate_front_o (rate_front),
    .rate_lr_o    (rate_lr),
    .rate_mic_o   (rate_mic)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (rd_take) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= legal ? words[slot] : '1;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/codec_mix_regfile_chk.sv
module codec_mix_regfile_chk
  import codec_mix_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic [WORD_W-1:0] rate_front,
  input logic [WORD_W-1:0] rate_lr,
  input logic [WORD_W-1:0] rate_mic,
  input logic [WORD_W-1:0] ext_ctl,
  input logic [WORD_W-1:0] pdown,
  input logic [WORD_W-1:0] ext_id
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R13

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R13

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid); // R13

  AST_AR_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ctl[VRA_BIT] |-> rate_front == RATE_48K && rate_lr == RATE_48K); // R5

  AST_MIC_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ctl[VRM_BIT] |-> rate_mic == RATE_48K); // R6

  AST_PD_STATUS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pdown[STATUS_W-1:0] == 4'hF); // R4

  AST_EXT_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_id == 16'h0809); // R3
endmodule

bind codec_mix_regfile codec_mix_regfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .rate_front (rate_front),
  .rate_lr    (rate_lr),
  .rate_mic   (rate_mic),
  .ext_ctl    (ext_ctl_w),
  .pdown      (pdown_w),
  .ext_id     (ext_id_w)
);

// File: tb/codec_mix_regfile_test.sv
module codec_mix_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NUM_CH     = 4;
  localparam int ATT_W      = 5;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [7:0]  idx;
    logic [15:0] val;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VECS [0:NV-1] = '{
    // R1 reset defaults
    '{1'b0, 2'd1, 8'h02, 16'h0000, 4'd1},
    '{1'b0, 2'd1, 8'h06, 16'h8000, 4'd1},
    '{1'b0, 2'd1, 8'h0C, 16'h8008, 4'd1},
    '{1'b0, 2'd1, 8'h0E, 16'h8008, 4'd1},
    '{1'b0, 2'd1, 8'h12, 16'h8808, 4'd1},
    '{1'b0, 2'd1, 8'h16, 16'h8808, 4'd1},
    '{1'b0, 2'd1, 8'h1E, 16'h8000, 4'd1},
    '{1'b0, 2'd1, 8'h26, 16'h000F, 4'd1},
    '{1'b0, 2'd1, 8'h28, 16'h0809, 4'd1},
    '{1'b0, 2'd1, 8'h2A, 16'h0009, 4'd1},
    '{1'b0, 2'd1, 8'h2C, 16'hBB80, 4'd1},
    '{1'b0, 2'd1, 8'h34, 16'hBB80, 4'd1},
    '{1'b0, 2'd1, 8'h7E, 16'h0000, 4'd1},
    // R2 plain stores
    '{1'b1, 2'd1, 8'h02, 16'h1F05, 4'd2},
    '{1'b0, 2'd1, 8'h02, 16'h1F05, 4'd2},
    '{1'b1, 2'd1, 8'h20, 16'hA55A, 4'd2},
    '{1'b0, 2'd1, 8'h20, 16'hA55A, 4'd2},
    // R3 read-only words
    '{1'b1, 2'd1, 8'h7C, 16'h1234, 4'd3},
    '{1'b0, 2'd1, 8'h7C, 16'h0000, 4'd3},
    '{1'b1, 2'd1, 8'h28, 16'hFFFF, 4'd3},
    '{1'b0, 2'd1, 8'h28, 16'h0809, 4'd3},
    // R4 power-down status nibble kept
    '{1'b1, 2'd1, 8'h26, 16'hA5A0, 4'd4},
    '{1'b0, 2'd1, 8'h26, 16'hA5AF, 4'd4},
    // R5 / R6 enabled rate writes
    '{1'b1, 2'd1, 8'h2C, 16'hAC44, 4'd5},
    '{1'b0, 2'd1, 8'h2C, 16'hAC44, 4'd5},
    '{1'b1, 2'd1, 8'h34, 16'h1F40, 4'd6},
    '{1'b0, 2'd1, 8'h34, 16'h1F40, 4'd6},
    // R7 clearing the audio enable pins front and stereo capture only
    '{1'b1, 2'd1, 8'h2A, 16'h0008, 4'd7},
    '{1'b0, 2'd1, 8'h2C, 16'hBB80, 4'd7},
    '{1'b0, 2'd1, 8'h32, 16'hBB80, 4'd7},
    '{1'b0, 2'd1, 8'h34, 16'h1F40, 4'd7},
    '{1'b0, 2'd1, 8'h2A, 16'h0008, 4'd7},
    // R5 disabled write dropped
    '{1'b1, 2'd1, 8'h2C, 16'h5622, 4'd5},
    '{1'b0, 2'd1, 8'h2C, 16'hBB80, 4'd5},
    // R7 clearing the mic enable
    '{1'b1, 2'd1, 8'h2A, 16'h0000, 4'd7},
    '{1'b0, 2'd1, 8'h34, 16'hBB80, 4'd7},
    // R6 disabled mic write dropped
    '{1'b1, 2'd1, 8'h34, 16'h2B11, 4'd6},
    '{1'b0, 2'd1, 8'h34, 16'hBB80, 4'd6},
    // R5 audio enable alone
    '{1'b1, 2'd1, 8'h2A, 16'h0001, 4'd5},
    '{1'b1, 2'd1, 8'h32, 16'h3E80, 4'd5},
    '{1'b0, 2'd1, 8'h32, 16'h3E80, 4'd5},
    '{1'b1, 2'd1, 8'h34, 16'h1111, 4'd6},
    '{1'b0, 2'd1, 8'h34, 16'hBB80, 4'd6},
    // R8 illegal accesses
    '{1'b1, 2'd1, 8'h05, 16'h1234, 4'd8},
    '{1'b0, 2'd1, 8'h04, 16'h0000, 4'd8},
    '{1'b0, 2'd1, 8'h06, 16'h8000, 4'd8},
    '{1'b0, 2'd1, 8'h03, 16'hFFFF, 4'd8},
    '{1'b0, 2'd1, 8'h80, 16'hFFFF, 4'd8},
    '{1'b1, 2'd0, 8'h10, 16'h7777, 4'd8},
    '{1'b0, 2'd1, 8'h10, 16'h0000, 4'd8},
    '{1'b0, 2'd0, 8'h06, 16'hFFFF, 4'd8},
    '{1'b0, 2'd2, 8'h06, 16'hFFFF, 4'd8},
    '{1'b1, 2'd2, 8'h10, 16'h5555, 4'd8},
    '{1'b0, 2'd1, 8'h10, 16'h0000, 4'd8},
    '{1'b1, 2'd1, 8'h80, 16'h4321, 4'd8},
    '{1'b0, 2'd1, 8'h00, 16'h0000, 4'd8}
  };

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    regs_reset = 1'b0;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic                    req_write = 1'b0;
  logic [1:0]              req_size = 2'd1;
  logic [7:0]              req_index = '0;
  logic [15:0]             req_wdata = '0;
  logic                    rsp_valid;
  logic                    rsp_ready = 1'b1;
  logic [15:0]             rsp_rdata;
  logic [NUM_CH-1:0]       vol_mute;
  logic [NUM_CH*ATT_W-1:0] vol_left;
  logic [NUM_CH*ATT_W-1:0] vol_right;
  logic [2:0]              rec_left;
  logic [2:0]              rec_right;
  logic [15:0]             rate_front;
  logic [15:0]             rate_lr;
  logic [15:0]             rate_mic;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_mix_regfile uut (
    .clk(clk), .rst_n(rst_n), .regs_reset(regs_reset),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .vol_mute(vol_mute), .vol_left(vol_left), .vol_right(vol_right),
    .rec_left(rec_left), .rec_right(rec_right),
    .rate_front(rate_front), .rate_lr(rate_lr), .rate_mic(rate_mic)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic [1:0] sz, input logic [7:0] idx, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_index = idx; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_op(input logic [1:0] sz, input logic [7:0] idx, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_index = idx;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 16'hxxxx;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R13 idle handshake, R9 R11 R10 decoded defaults
    chk("R13 req_ready after reset", 32'(req_ready), 32'd1);
    chk("R13 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R9 mic ch3 mute default", 32'(vol_mute[3]), 32'd1);
    chk("R9 mic ch3 left default", 32'(vol_left[3*ATT_W +: ATT_W]), 32'd31);
    chk("R9 mic ch3 right default", 32'(vol_right[3*ATT_W +: ATT_W]), 32'd23);
    chk("R11 front rate default", 32'(rate_front), 32'hBB80);
    chk("R10 rec default", 32'({rec_left, rec_right}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        wr_op(VECS[i].sz, VECS[i].idx, VECS[i].val);
      end else begin
        rd_op(VECS[i].sz, VECS[i].idx, d);
        chk($sformatf("R%0d vector %0d index %h", VECS[i].req, i, VECS[i].idx),
            32'(d), 32'(VECS[i].val));
      end
    end

    // R9 volume decode after write
    wr_op(2'd1, 8'h02, 16'h8A03);
    chk("R9 master mute", 32'(vol_mute[0]), 32'd1);
    chk("R9 master left", 32'(vol_left[0 +: ATT_W]), 32'd21);
    chk("R9 master right", 32'(vol_right[0 +: ATT_W]), 32'd28);
    wr_op(2'd1, 8'h18, 16'h001F);
    chk("R9 pcm mute", 32'(vol_mute[2]), 32'd0);
    chk("R9 pcm left", 32'(vol_left[2*ATT_W +: ATT_W]), 32'd31);
    chk("R9 pcm right", 32'(vol_right[2*ATT_W +: ATT_W]), 32'd0);

    // R10 record select
    wr_op(2'd1, 8'h1A, 16'h0504);
    chk("R10 rec left", 32'(rec_left), 32'd5);
    chk("R10 rec right", 32'(rec_right), 32'd4);

    // R11 live rates
    chk("R11 stereo capture rate", 32'(rate_lr), 32'h3E80);
    chk("R11 front rate", 32'(rate_front), 32'hBB80);
    chk("R11 mic rate", 32'(rate_mic), 32'hBB80);

    // R13 stall: response held while rsp_ready is low
    rsp_ready = 1'b0;
    rd_op(2'd1, 8'h1A, d);
    chk("R13 stalled data", 32'(d), 32'h0504);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd1; req_index = 8'h20; req_wdata = 16'h0000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R13 rsp_valid held", 32'(rsp_valid), 32'd1);
      chk("R13 req_ready low", 32'(req_ready), 32'd0);
      chk("R13 data stable", 32'(rsp_rdata), 32'h0504);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R13 rsp released", 32'(rsp_valid), 32'd0);
    rd_op(2'd1, 8'h20, d);
    chk("R13 stalled write not taken", 32'(d), 32'hA55A);

    // R12 register reset
    @(negedge clk);
    regs_reset = 1'b1;
    @(negedge clk);
    regs_reset = 1'b0;
    chk("R12 rate_lr restored", 32'(rate_lr), 32'hBB80);
    chk("R12 rec restored", 32'({rec_left, rec_right}), 32'd0);
    rd_op(2'd1, 8'h02, d);
    chk("R12 master restored", 32'(d), 32'h0000);
    rd_op(2'd1, 8'h2A, d);
    chk("R12 ext ctl restored", 32'(d), 32'h0009);
    rd_op(2'd1, 8'h26, d);
    chk("R12 power-down restored", 32'(d), 32'h000F);
    rd_op(2'd1, 8'h20, d);
    chk("R12 general word restored", 32'(d), 32'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule